// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block collects 8-bit frames from a serial data line that is qualified by a separate serial clock. The serial clock may be produced elsewhere on the chip or arrive from a pin; either way it is brought into the system clock domain and its rising edges mark the bit boundaries. Bits are gathered in a hidden shift register, least significant bit first. When the eighth bit lands, the byte is handed to a host-visible data register, and a full flag is raised.

When the host is too slow, a completed frame finds the full flag still set. The block then keeps the unread byte, discards the new one and raises an overrun flag. That condition takes precedence over the normal receive request. The host sees three registers through a small read/write port: the received byte, a status word with the two flags, and a control word with a receive enable and an interrupt enable. Two level interrupt requests follow the flags.

Register map (2-bit address): address 0 is the received byte (read only). Address 1 is status: bit 0 full, bit 1 overrun. Address 2 is control: bit 0 receive enable, bit 1 interrupt enable. Address 3 reads as zero.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset the data register, status and control read 0 and both interrupt requests are low.
- R2: With receive enabled, the data level on each of eight rising serial clock edges forms one byte, the first bit as bit 0 and the last as bit 7. When the byte completes with both flags clear, it appears at address 0 and status bit 0 (full) becomes 1.
- R3: irq_rx is high exactly while full is 1, overrun is 0 and control bit 1 is 1.
- R4: A frame completing while full is 1 sets status bit 1 (overrun), leaves the data register unchanged and keeps full at 1.
- R5: irq_err is high exactly while overrun is 1 and control bit 1 is 1, and irq_rx is then low.
- R6: Writing status clears each flag whose written bit is 0. A written 1 leaves that flag unchanged. Writes to address 0 have no effect.
- R7: While overrun is 1 and full is 0, a completed frame is dropped: the data register and full stay unchanged.
- R8: While control bit 0 is 0, serial clock edges change no flag and no data. Clearing the bit discards a partly received frame, so the next frame starts at bit 0.
- R9: With control bit 1 at 0, both interrupt requests stay low whatever the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, asynchronous to clk |
| sdi | input | 1 | Serial data, sampled on rising sck |
| bus_addr | input | 2 | Host register address |
| bus_wr | input | 1 | Host write strobe, one clk cycle per write |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data for bus_addr |
| irq_rx | output | 1 | Receive-complete request (level) |
| irq_err | output | 1 | Overrun error request (level) |

## Verification
The bench sends a back-to-back second frame without clearing full. A design that overwrote the byte, or let irq_rx stay up next to irq_err, would show the wrong data or both requests high. It also clears only full and leaves overrun set, then sends again. A receiver that resumed transfers there would load the new byte. A frame abandoned halfway by dropping the enable is followed by a clean frame, and a bit counter that survived the disable would misalign that byte. Writes of 1 to the status bits and writes to the data address must leave everything as it was. A design that toggled flags or loaded data on any write would fail those checks.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA   = 2'd0,
    REG_STATUS = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;

  localparam int ST_FULL = 0;
  localparam int ST_OVR  = 1;
  localparam int CT_RXEN = 0;
  localparam int CT_IREN = 1;
endpackage

// File: rtl/sr_sync_edge.sv
module sr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdi_in,
  output logic sck_rise,
  output logic sdi_sync
);
  logic [STAGES-1:0] sck_chain, sdi_chain;
  logic              sck_last;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sck_chain[0] <= 1'b0;
            sdi_chain[0] <= 1'b0;
          end else begin
            sck_chain[0] <= sck_in;
            sdi_chain[0] <= sdi_in;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            sck_chain[g] <= 1'b0;
            sdi_chain[g] <= 1'b0;
          end else begin
            sck_chain[g] <= sck_chain[g-1];
            sdi_chain[g] <= sdi_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_last <= 1'b0;
    else        sck_last <= sck_chain[STAGES-1];
  end

  assign sck_rise = sck_chain[STAGES-1] & ~sck_last;
  assign sdi_sync = sdi_chain[STAGES-1];
endmodule

// File: rtl/sr_shifter.sv
module sr_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         bit_strobe,
  input  logic         bit_val,
  output logic         frame_done,
  output logic [W-1:0] frame_byte
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     shreg_q, shreg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign frame_byte = {bit_val, shreg_q[W-1:1]};
  assign frame_done = enable & bit_strobe & (cnt_q == LAST);

  always_comb begin
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    if (!enable) begin
      shreg_d = '0;
      cnt_d   = '0;
    end else if (bit_strobe) begin
      shreg_d = frame_byte;
      cnt_d   = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/sr_regs.sv
module sr_regs
  import sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_byte,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] data_q,
  output logic              full_q,
  output logic              ovr_q,
  output logic              rxen_q,
  output logic              iren_q
);
  logic [DATA_W-1:0] data_d;
  logic full_d, ovr_d, rxen_d, iren_d;
  logic wr_status, wr_ctrl;

  assign wr_status = bus_wr & (bus_addr == REG_STATUS);
  assign wr_ctrl   = bus_wr & (bus_addr == REG_CTRL);

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    rxen_d = rxen_q;
    iren_d = iren_q;
    if (wr_status) begin
      if (!bus_wdata[ST_FULL]) full_d = 1'b0;
      if (!bus_wdata[ST_OVR])  ovr_d  = 1'b0;
    end
    if (wr_ctrl) begin
      rxen_d = bus_wdata[CT_RXEN];
      iren_d = bus_wdata[CT_IREN];
    end
    if (frame_done) begin
      if (full_q) begin
        ovr_d  = 1'b1;
        full_d = 1'b1;
      end else if (!ovr_q) begin
        data_d = frame_byte;
        full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      rxen_q <= 1'b0;
      iren_q <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
      rxen_q <= rxen_d;
      iren_q <= iren_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_DATA:   bus_rdata = data_q;
      REG_STATUS: begin
        bus_rdata[ST_FULL] = full_q;
        bus_rdata[ST_OVR]  = ovr_q;
      end
      REG_CTRL: begin
        bus_rdata[CT_RXEN] = rxen_q;
        bus_rdata[CT_IREN] = iren_q;
      end
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              sdi,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_rx,
  output logic              irq_err
);
  logic rst_meta, rst_q;
  logic sck_rise, sdi_s;
  logic frame_done;
  logic [DATA_W-1:0] frame_byte, data_q;
  logic full_q, ovr_q, rxen_q, iren_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  sr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .sck_in(sck), .sdi_in(sdi),
    .sck_rise(sck_rise), .sdi_sync(sdi_s)
  );

  sr_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_q), .enable(rxen_q), .bit_strobe(sck_rise),
    .bit_val(sdi_s), .frame_done(frame_done), .frame_byte(frame_byte)
  );

  sr_regs u_regs (
    .clk(clk), .rst_n(rst_q), .frame_done(frame_done), .frame_byte(frame_byte),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .data_q(data_q), .full_q(full_q), .ovr_q(ovr_q),
    .rxen_q(rxen_q), .iren_q(iren_q)
  );

  assign irq_err = ovr_q & iren_q;
  assign irq_rx  = full_q & iren_q & ~ovr_q;
endmodule

// File: rtl/sync_serial_rx_chk.sv
module sync_serial_rx_chk (
  input logic       clk,
  input logic       rst_q,
  input logic       frame_done,
  input logic [7:0] frame_byte,
  input logic [7:0] data_q,
  input logic       full_q,
  input logic       ovr_q,
  input logic       rxen_q,
  input logic       iren_q,
  input logic       bus_wr,
  input logic       irq_rx,
  input logic       irq_err
);
  // R2
  load_on_done_chk: assert property (@(posedge clk) disable iff (!rst_q)
    frame_done && !full_q && !ovr_q |=> full_q && data_q == $past(frame_byte));
  // R4
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_q)
    frame_done && full_q |=> ovr_q && full_q && $stable(data_q));
  // R7
  drop_while_ovr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    frame_done && ovr_q && !full_q |=> !full_q && $stable(data_q));
  // R5
  irq_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !(irq_rx && irq_err));
  // R3
  irq_rx_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_q)
    irq_rx |-> full_q && iren_q);
  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !iren_q |-> !irq_rx && !irq_err);
  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !rxen_q && !bus_wr |=> $stable(full_q) && $stable(ovr_q) && $stable(data_q));
endmodule

bind sync_serial_rx sync_serial_rx_chk u_chk (
  .clk(clk), .rst_q(rst_q), .frame_done(frame_done), .frame_byte(frame_byte),
  .data_q(data_q), .full_q(full_q), .ovr_q(ovr_q), .rxen_q(rxen_q),
  .iren_q(iren_q), .bus_wr(bus_wr), .irq_rx(irq_rx), .irq_err(irq_err)
);

// File: tb/tb_sync_serial_rx.sv
`timescale 1ns/1ps
module tb_sync_serial_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic irq_rx, irq_err;
  int checks = 0;
  int errors = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  sync_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sdi(sdi), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_err(irq_err)
  );

  // byte to send, expected data, expected status after the frame
  localparam int NV = 5;
  localparam logic [7:0] VEC_TX [NV] = '{8'hA5, 8'h01, 8'h80, 8'h3C, 8'hFF};
  localparam logic [7:0] VEC_RD [NV] = '{8'hA5, 8'h01, 8'h80, 8'h3C, 8'hFF};
  localparam logic [1:0] VEC_ST [NV] = '{2'b01, 2'b01, 2'b01, 2'b01, 2'b01};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sck = 1'b0; sdi = b[i];
      #40;
      sck = 1'b1;
      #40;
    end
    sck = 1'b0;
    #100;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1 reset state
    rd(2'd0, v); check("R1 data", v, 8'h00);
    rd(2'd1, v); check("R1 status", v, 8'h00);
    rd(2'd2, v); check("R1 ctrl", v, 8'h00);
    check("R1 irqs", {6'd0, irq_rx, irq_err}, 8'h00);

    // R8 disabled: frame ignored
    send_bits(8'h5A, 8);
    rd(2'd1, v); check("R8 disabled status", v, 8'h00);
    rd(2'd0, v); check("R8 disabled data", v, 8'h00);

    wr(2'd2, 8'h03);
    rd(2'd2, v); check("R8 ctrl readback", v, 8'h03);

    // R2 R3 vector table
    for (int k = 0; k < NV; k++) begin
      send_bits(VEC_TX[k], 8);
      rd(2'd0, v); check("R2 data", v, VEC_RD[k]);
      rd(2'd1, v); check("R2 status", v, {6'd0, VEC_ST[k]});
      check("R3 irq_rx", {6'd0, irq_rx, irq_err}, 8'h02);
      wr(2'd1, 8'h00);
      check("R3 irq_rx cleared", {6'd0, irq_rx, irq_err}, 8'h00);
    end

    // R6 writes of 1 and writes to data have no effect
    send_bits(8'h42, 8);
    wr(2'd1, 8'h03);
    rd(2'd1, v); check("R6 write ones", v, 8'h01);
    wr(2'd0, 8'h99);
    rd(2'd0, v); check("R6 data write ignored", v, 8'h42);

    // R4 R5 overrun
    send_bits(8'hC3, 8);
    rd(2'd0, v); check("R4 data kept", v, 8'h42);
    rd(2'd1, v); check("R4 status", v, 8'h03);
    check("R5 irqs", {6'd0, irq_rx, irq_err}, 8'h01);

    // R9 mask
    wr(2'd2, 8'h01);
    check("R9 masked", {6'd0, irq_rx, irq_err}, 8'h00);
    wr(2'd2, 8'h03);

    // R7 drop while overrun set
    wr(2'd1, 8'h02);
    rd(2'd1, v); check("R6 clear full only", v, 8'h02);
    send_bits(8'h77, 8);
    rd(2'd0, v); check("R7 data unchanged", v, 8'h42);
    rd(2'd1, v); check("R7 status", v, 8'h02);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 clear all", v, 8'h00);

    // R8 partial frame discarded by disable
    send_bits(8'h0F, 3);
    wr(2'd2, 8'h02);
    wr(2'd2, 8'h03);
    send_bits(8'h96, 8);
    rd(2'd0, v); check("R8 realigned", v, 8'h96);
    rd(2'd1, v); check("R8 status", v, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule